// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is the noise voice of a retro sound generator. A programmable period timer, clocked from the 4194304 Hz system clock, advances a 15-bit feedback shift register. A configuration bit shortens the sequence to 7 bits by also feeding the new bit into bit 6. The waveform bit is the inverse of the register's lowest bit. A volume envelope, advanced by an external 64 Hz tick, sets the output level.

Software writes two registers: a timing register (clock shift, short-sequence select, divisor code) and an envelope register (start volume, direction, step period). A trigger strobe restarts the voice. The outputs are a 4-bit level and a flag showing that the voice is running. Length counting, conversion to analogue, panning and mixing belong to other blocks.

Top module: `noise_voice`

## Requirements
- R1: After reset, `active` is 0 and `level` is 0.
- R2: On each timer step, the register shifts right by one. Bit 14 receives bit 0 XOR bit 1 of the value before the shift.
- R3: When `tmrShort` is 1 at latch time, each step also writes that same XOR result into bit 6, after the shift.
- R4: `level` equals the current volume when `active` is 1 and register bit 0 is 0. Otherwise `level` is 0.
- R5: A trigger sets all 15 register bits to 1 and reloads the period timer. The first step lands exactly one period after the trigger edge, and later steps follow every period.
- R6: The period in system clocks is base << `tmrShift`. The base is 8 for `tmrDiv` = 0 and 16 × `tmrDiv` for `tmrDiv` = 1 to 7.
- R7: With a latched `tmrShift` of 14 or 15, the register never steps and `level` holds.
- R8: With a nonzero envelope period p, the volume moves by one on every p-th `envTick` after the trigger. It goes up when `envRise` is 1 and down when it is 0.
- R9: A step that would leave the range 0 to 15 leaves the volume unchanged. It also stops all further envelope steps until the next trigger, even after the envelope register is rewritten.
- R10: An envelope period of 0 makes no volume steps, and its tick counter is loaded with 8. If a nonzero period is written later, the first step still comes on the 8th tick after the trigger.
- R11: A trigger loads the volume from `envStartVol`.
- R12: When `envStartVol` is 0 and `envRise` is 0, the converter is off. `active` then goes to 0 on the next clock, and a trigger does not set it.
- R13: A register write in the same cycle as `trigger` takes effect for that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4194304 Hz in the target |
| rstN | input | 1 | Asynchronous reset, active low |
| trigger | input | 1 | One-cycle restart strobe |
| envTick | input | 1 | One-cycle 64 Hz envelope tick |
| tmrWr | input | 1 | Write strobe for the timing register |
| tmrShift | input | 4 | Clock shift applied to the base divisor |
| tmrShort | input | 1 | 1 selects the 7-bit sequence |
| tmrDiv | input | 3 | Divisor code |
| envWr | input | 1 | Write strobe for the envelope register |
| envStartVol | input | 4 | Volume loaded on trigger |
| envRise | input | 1 | Envelope direction, 1 counts up |
| envPeriod | input | 3 | Ticks per envelope step, 0 disables steps |
| level | output | 4 | Output sample |
| active | output | 1 | Voice running flag |

## Verification
A trigger takes effect at the clock edge that samples it, so at the next falling edge `level` already shows the all-ones register, and the n-th step shows up just after edge n × period. The bench counts clock edges from the trigger edge and samples at each falling edge. It recomputes the expected register with its own model at every multiple of the period, so a step one cycle early or late is caught. Envelope results appear one clock after the tick that causes them, and the converter-off clear of `active` is due one clock after the envelope write. Each check samples at the falling edge that follows the causing edge.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int LFSR_W     = 15;
  localparam int SHORT_TAP  = 6;
  localparam int VOL_W      = 4;
  localparam int ENV_PER_W  = 3;
  localparam int DIV_W      = 3;
  localparam int SHIFT_W    = 4;
  localparam int BASE_UNIT  = 16;
  localparam int ZERO_BASE  = 8;
  localparam int STOP_SHIFT = 14;
  localparam int BASE_W     = $clog2(((1 << DIV_W) - 1) * BASE_UNIT + 1);
  localparam int PER_W      = BASE_W + STOP_SHIFT - 1;
  localparam int ENV_CNT_W  = ENV_PER_W + 1;

  typedef struct packed {
    logic             trig;
    logic             lfsrStep;
    logic             envStep;
    logic             envUp;
    logic             shortMode;
    logic [VOL_W-1:0] initVol;
  } noiseStrobe_t;
endpackage

// File: rtl/noise_ctrl.sv
module noise_ctrl
  import noise_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigger,
  input  logic                 envTick,
  input  logic                 tmrWr,
  input  logic [SHIFT_W-1:0]   tmrShift,
  input  logic                 tmrShort,
  input  logic [DIV_W-1:0]     tmrDiv,
  input  logic                 envWr,
  input  logic [VOL_W-1:0]     envStartVol,
  input  logic                 envRise,
  input  logic [ENV_PER_W-1:0] envPeriod,
  output noiseStrobe_t         strobe,
  output logic                 active
);
  logic [SHIFT_W-1:0]   shiftQ, shiftE;
  logic                 shortQ, shortE;
  logic [DIV_W-1:0]     divQ, divE;
  logic [VOL_W-1:0]     volQ, volE;
  logic                 riseQ, riseE;
  logic [ENV_PER_W-1:0] perQ, perE;

  // a write in the trigger cycle is visible to that trigger
  assign shiftE = tmrWr ? tmrShift    : shiftQ;
  assign shortE = tmrWr ? tmrShort    : shortQ;
  assign divE   = tmrWr ? tmrDiv      : divQ;
  assign volE   = envWr ? envStartVol : volQ;
  assign riseE  = envWr ? envRise     : riseQ;
  assign perE   = envWr ? envPeriod   : perQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0; shortQ <= 1'b0; divQ <= '0;
      volQ   <= '0; riseQ  <= 1'b0; perQ <= '0;
    end else begin
      if (tmrWr) begin
        shiftQ <= tmrShift; shortQ <= tmrShort; divQ <= tmrDiv;
      end
      if (envWr) begin
        volQ <= envStartVol; riseQ <= envRise; perQ <= envPeriod;
      end
    end
  end

  // period timer
  logic [BASE_W-1:0] baseVal;
  logic [PER_W-1:0]  periodE, cntQ;
  logic              timerHit;

  assign baseVal  = (divE == '0) ? BASE_W'(ZERO_BASE)
                                 : BASE_W'(divE) * BASE_W'(BASE_UNIT);
  assign periodE  = PER_W'(baseVal) << shiftE;
  assign timerHit = (cntQ <= PER_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cntQ <= PER_W'(ZERO_BASE);
    else if (trigger || timerHit) cntQ <= periodE;
    else                         cntQ <= cntQ - PER_W'(1);
  end

  // envelope tick divider
  logic [ENV_CNT_W-1:0] envCntQ, envReload;
  logic                 envHit;

  assign envReload = (perE == '0) ? ENV_CNT_W'(1 << ENV_PER_W) : {1'b0, perE};
  assign envHit    = envTick && (envCntQ <= ENV_CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        envCntQ <= ENV_CNT_W'(1 << ENV_PER_W);
    else if (trigger) envCntQ <= envReload;
    else if (envHit)  envCntQ <= envReload;
    else if (envTick) envCntQ <= envCntQ - ENV_CNT_W'(1);
  end

  // converter power and running flag
  logic dacOnE, dacOnQ, activeQ;
  assign dacOnE = (volE != '0) || riseE;
  assign dacOnQ = (volQ != '0) || riseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= dacOnE && (trigger || activeQ);
  end
  assign active = activeQ;

  always_comb begin
    strobe           = '0;
    strobe.trig      = trigger;
    strobe.lfsrStep  = timerHit && !trigger && (shiftQ < SHIFT_W'(STOP_SHIFT));
    strobe.envStep   = envHit && !trigger && (perE != '0);
    strobe.envUp     = riseE;
    strobe.shortMode = shortQ;
    strobe.initVol   = volE;
  end

  p_dac_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    !dacOnQ |-> !activeQ);
  p_stop_codes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftQ >= SHIFT_W'(STOP_SHIFT)) |-> !strobe.lfsrStep);
  p_step_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lfsrStep |=> cntQ == $past(periodE));
  p_trig_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigger |=> cntQ == $past(periodE));
endmodule

// File: rtl/noise_dp.sv
module noise_dp
  import noise_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  noiseStrobe_t     strobe,
  input  logic             active,
  output logic [VOL_W-1:0] level
);
  logic [LFSR_W-1:0] lfsrQ, lfsrNxt;
  logic              fb;

  assign fb = lfsrQ[0] ^ lfsrQ[1];

  for (genvar b = 0; b < LFSR_W; b++) begin : g_bit
    if (b == LFSR_W - 1) begin : g_top
      assign lfsrNxt[b] = fb;
    end else if (b == SHORT_TAP) begin : g_tap
      assign lfsrNxt[b] = strobe.shortMode ? fb : lfsrQ[b+1];
    end else begin : g_mid
      assign lfsrNxt[b] = lfsrQ[b+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lfsrQ <= '1;
    else if (strobe.trig)     lfsrQ <= '1;
    else if (strobe.lfsrStep) lfsrQ <= lfsrNxt;
  end

  // envelope volume with sticky stop
  logic [VOL_W-1:0] volQ;
  logic             stopQ;
  localparam logic [VOL_W-1:0] VOL_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volQ  <= '0;
      stopQ <= 1'b0;
    end else if (strobe.trig) begin
      volQ  <= strobe.initVol;
      stopQ <= 1'b0;
    end else if (strobe.envStep && !stopQ) begin
      if (strobe.envUp) begin
        if (volQ == VOL_MAX) stopQ <= 1'b1;
        else                 volQ  <= volQ + VOL_W'(1);
      end else begin
        if (volQ == '0)      stopQ <= 1'b1;
        else                 volQ  <= volQ - VOL_W'(1);
      end
    end
  end

  assign level = (active && !lfsrQ[0]) ? volQ : '0;

  p_trig_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trig |=> (&lfsrQ));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.trig && !strobe.lfsrStep) |=> $stable(lfsrQ));
  p_long_fb_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lfsrStep |=> lfsrQ[LFSR_W-1] == ($past(lfsrQ[0]) ^ $past(lfsrQ[1])));
  p_short_tap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lfsrStep && strobe.shortMode) |=> lfsrQ[SHORT_TAP] == lfsrQ[LFSR_W-1]);
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && !strobe.trig) |=> $stable(volQ));
  p_env_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.trig && !strobe.envStep) |=> $stable(volQ));
  p_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (level != '0) |-> active);
endmodule

// File: rtl/noise_voice.sv
module noise_voice
  import noise_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigger,
  input  logic                 envTick,
  input  logic                 tmrWr,
  input  logic [SHIFT_W-1:0]   tmrShift,
  input  logic                 tmrShort,
  input  logic [DIV_W-1:0]     tmrDiv,
  input  logic                 envWr,
  input  logic [VOL_W-1:0]     envStartVol,
  input  logic                 envRise,
  input  logic [ENV_PER_W-1:0] envPeriod,
  output logic [VOL_W-1:0]     level,
  output logic                 active
);
  noiseStrobe_t strobe;

  noise_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .envTick(envTick),
    .tmrWr(tmrWr), .tmrShift(tmrShift), .tmrShort(tmrShort), .tmrDiv(tmrDiv),
    .envWr(envWr), .envStartVol(envStartVol), .envRise(envRise),
    .envPeriod(envPeriod), .strobe(strobe), .active(active)
  );

  noise_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(active), .level(level)
  );
endmodule

// File: tb/sim_noise_voice.sv
module sim_noise_voice;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0, envTick = 1'b0, tmrWr = 1'b0, envWr = 1'b0;
  logic [3:0] tmrShift = '0;
  logic tmrShort = 1'b0;
  logic [2:0] tmrDiv = '0;
  logic [3:0] envStartVol = '0;
  logic envRise = 1'b0;
  logic [2:0] envPeriod = '0;
  logic [3:0] level;
  logic active;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  noise_voice u0 (
    .clk(clk), .rstN(rstN), .trigger(trigger), .envTick(envTick),
    .tmrWr(tmrWr), .tmrShift(tmrShift), .tmrShort(tmrShort), .tmrDiv(tmrDiv),
    .envWr(envWr), .envStartVol(envStartVol), .envRise(envRise),
    .envPeriod(envPeriod), .level(level), .active(active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] modelStep(input logic [14:0] s, input logic sh);
    logic f;
    logic [14:0] r;
    f = s[0] ^ s[1];
    r = {f, s[14:1]};
    if (sh) r[6] = f;
    return r;
  endfunction

  // all tasks start and end at a falling edge
  task automatic fire(input int sft, input bit sh, input int dv,
                      input int vol, input bit up, input int per);
    tmrShift = 4'(sft); tmrShort = sh; tmrDiv = 3'(dv);
    envStartVol = 4'(vol); envRise = up; envPeriod = 3'(per);
    tmrWr = 1'b1; envWr = 1'b1; trigger = 1'b1;
    @(negedge clk);
    tmrWr = 1'b0; envWr = 1'b0; trigger = 1'b0;
  endtask

  task automatic setTmr(input int sft, input bit sh, input int dv);
    tmrShift = 4'(sft); tmrShort = sh; tmrDiv = 3'(dv); tmrWr = 1'b1;
    @(negedge clk);
    tmrWr = 1'b0;
  endtask

  task automatic setEnv(input int vol, input bit up, input int per);
    envStartVol = 4'(vol); envRise = up; envPeriod = 3'(per); envWr = 1'b1;
    @(negedge clk);
    envWr = 1'b0;
  endtask

  task automatic tick();
    envTick = 1'b1;
    @(negedge clk);
    envTick = 1'b0;
  endtask

  // run 15 steps of period 8 (bit 0 becomes 0), then stop the register
  task automatic freeze(input int vol, input bit up, input int per, input int stopCode);
    fire(0, 1'b0, 0, vol, up, per);
    repeat (120) @(negedge clk);
    setTmr(stopCode, 1'b0, 0);
    chk("R4 frozen level", int'(level), vol);
  endtask

  task automatic runSeq(input string tag, input bit sh, input int dv,
                        input int sft, input int steps, input int vol);
    int p;
    logic [14:0] s;
    p = ((dv == 0) ? 8 : dv * 16) << sft;
    fire(sft, sh, dv, vol, 1'b1, 0);
    s = '1;
    for (int n = 0; n <= p * steps; n++) begin
      if (n > 0 && (n % p) == 0) s = modelStep(s, sh);
      chk(tag, int'(level), s[0] ? 0 : vol);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 active", int'(active), 0);
    chk("R1 level", int'(level), 0);
  endtask

  task automatic t_long();
    runSeq("R2/R5/R4 long", 1'b0, 0, 0, 50, 9);
  endtask

  task automatic t_short();
    runSeq("R3 short", 1'b1, 1, 1, 140, 6);
  endtask

  task automatic t_div();
    runSeq("R6 divisor", 1'b0, 3, 2, 20, 12);
    runSeq("R5 retrigger", 1'b0, 7, 0, 12, 5);
  endtask

  task automatic t_stop();
    freeze(7, 1'b1, 0, 14);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k % 100 == 0) chk("R7 shift 14 holds", int'(level), 7);
    end
    freeze(11, 1'b1, 0, 15);
    repeat (3000) @(negedge clk);
    chk("R7 shift 15 holds", int'(level), 11);
  endtask

  task automatic t_envUp();
    freeze(3, 1'b1, 2, 14);
    for (int k = 1; k <= 30; k++) begin
      int e;
      tick();
      e = 3 + k / 2;
      if (e > 15) e = 15;
      chk("R8/R9 rise", int'(level), e);
    end
    setEnv(3, 1'b0, 1);
    repeat (5) tick();
    chk("R9 stopped after rewrite", int'(level), 15);
    freeze(3, 1'b1, 2, 14);
    chk("R11 reload on trigger", int'(level), 3);
  endtask

  task automatic t_envDown();
    freeze(2, 1'b0, 1, 14);
    tick(); chk("R8 fall", int'(level), 1);
    tick(); chk("R8 fall", int'(level), 0);
    tick(); tick();
    chk("R9 floor", int'(level), 0);
    chk("R9 still active", int'(active), 1);
  endtask

  task automatic t_envZero();
    freeze(5, 1'b1, 0, 14);
    repeat (10) tick();
    chk("R10 no steps", int'(level), 5);
    freeze(5, 1'b1, 0, 14);
    setEnv(5, 1'b1, 1);
    for (int k = 1; k <= 9; k++) begin
      tick();
      chk("R10 counter of 8", int'(level), (k < 8) ? 5 : 5 + k - 7);
    end
  endtask

  task automatic t_dac();
    fire(0, 1'b0, 0, 0, 1'b0, 0);
    chk("R12 trigger with converter off", int'(active), 0);
    freeze(4, 1'b1, 0, 14);
    chk("R12 running", int'(active), 1);
    setEnv(0, 1'b0, 0);
    chk("R12 cleared", int'(active), 0);
    chk("R12 level", int'(level), 0);
    fire(0, 1'b0, 0, 4, 1'b0, 0);
    chk("R13 same-cycle write", int'(active), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_long();
    t_short();
    t_div();
    t_stop();
    t_envUp();
    t_envDown();
    t_envZero();
    t_dac();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule